// File: doc/BRIEF.md
# UDP Register Access Handler

This block lets a host read and write on-chip control registers by sending small request payloads over UDP. Upstream logic strips the Ethernet, IP and UDP headers. It passes the UDP payload in as a stream of 16-bit words, along with the destination port of the datagram. The handler keeps only datagrams aimed at control port 1001. It parses each request into a type code, a register address and a data word, and steers the access to one of several register groups through a two-level address decoder. It then returns a response that the host side sends back on the same port 1001.

A request payload is five 16-bit words, in this order: the type code, the upper half of the address, the lower half of the address, the upper half of the data, and the lower half of the data. Type 0x2000 asks for a read and type 0x2001 asks for a write. Bits 31:28 of the address pick a domain and bits 27:24 pick a subsystem within the radio-platform domain. The low address bits pick a register inside the selected group. A bank of stub registers, one group per decodable target, stands in for the real subsystems.

Top module: `rah_udp_reg_handler`

## Requirements
- R1: A read (type 0x2000) of a decodable address produces a response with type 0x2000, the request address echoed, and the data last written to that register.
- R2: A write (type 0x2001) to a decodable address stores the data word. The response echoes type 0x2001, the address and the written data.
- R3: Address bits 31:28 equal to 0x0 or 0x1 select the processor-core register group. Bit 28 is ignored, so both values reach the same registers.
- R4: With bits 31:28 equal to 0x2, bits 27:24 pick a group: 0x0 common, 0x1 Ethernet, 0x2 packet, 0x4 to 0xB eight application slots, 0xC DAC interface, 0xD ADC interface. Each group is distinct. Within a group, address bits 1:0 pick one of four registers and bits 23:2 are ignored.
- R5: A request whose bits 31:28 are 0x3 to 0xF, or whose bits 31:28 are 0x2 and bits 27:24 are 0x3, 0xE or 0xF, gets a response with data 0 and changes no register.
- R6: A request with any type code other than 0x2000 or 0x2001 gets no response and changes no register.
- R7: A datagram whose destination port, sampled with its first word, is not 1001 gets no response and changes no register.
- R8: A frame (words up to and including the one flagged last) that ends before its fifth word is dropped. Words after the fifth are ignored, and the request is served once.
- R9: The response is valid for exactly one cycle. It is raised by the third rising clock edge, counting the edge that accepts the fifth payload word as the first.
- R10: After reset, no response is valid until a request has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A payload word is present this cycle |
| in_last | input | 1 | This payload word ends the datagram |
| in_dport | input | 16 | UDP destination port; sampled with the first word |
| in_data | input | 16 | Payload word |
| rsp_valid | output | 1 | Response is present this cycle |
| rsp_type | output | 16 | Response type code |
| rsp_addr | output | 32 | Echoed register address |
| rsp_data | output | 32 | Read data, echoed write data, or 0 on a miss |

## Verification
The assertions assume that payload words arrive at most one per cycle and that every datagram is closed by a word flagged last. The one-cycle response pulse and its fixed distance from an accepted word both rest on requests being at least five words apart. The stimulus sends whole frames from a task, one word per cycle, and leaves idle cycles between frames. The destination port is held for the whole frame, so only the first-word sampling can matter. The sweep writes and reads every register of every target. It then probes each unused domain and subsystem, illegal types, wrong ports, and short and long frames, and ends by reading every register again to show that nothing was changed.

// File: rtl/rah_pkg.sv
package rah_pkg;
  localparam logic [15:0] TYPE_RD   = 16'h2000;
  localparam logic [15:0] TYPE_WR   = 16'h2001;
  localparam logic [15:0] CTRL_PORT = 16'd1001;
  // decodable targets: core group, three fixed radio groups, eight app slots, DAC, ADC
  localparam int NUM_TGT = 14;
  localparam int TGT_W   = $clog2(NUM_TGT);
endpackage

// File: rtl/rah_req_parser.sv
module rah_req_parser
  import rah_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [15:0]       in_dport,
  input  logic [WORD_W-1:0] in_data,
  output logic              req_v,
  output logic              req_wr,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data
);
  localparam int NWORDS  = 1 + ADDR_W / WORD_W + DATA_W / WORD_W;
  localparam int FRAME_W = NWORDS * WORD_W;
  localparam int SH_W    = FRAME_W - WORD_W;
  localparam int CNT_W   = $clog2(NWORDS + 1);

  logic [CNT_W-1:0]   cnt;
  logic               port_ok;
  logic [SH_W-1:0]    shreg;
  logic [FRAME_W-1:0] full;
  logic [WORD_W-1:0]  typ;
  logic               port_now;
  logic               type_ok;
  logic               complete;

  assign full     = {shreg, in_data};
  assign typ      = full[FRAME_W-1 -: WORD_W];
  assign port_now = (cnt == '0) ? (in_dport == CTRL_PORT) : port_ok;
  assign type_ok  = (typ == WORD_W'(TYPE_RD)) || (typ == WORD_W'(TYPE_WR));
  assign complete = in_valid && (cnt == CNT_W'(NWORDS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      port_ok <= 1'b0;
      req_v   <= 1'b0;
    end else begin
      req_v <= complete && port_now && type_ok;
      if (in_valid) begin
        if (cnt == '0)
          port_ok <= in_dport == CTRL_PORT;
        if (in_last)
          cnt <= '0;
        else if (cnt != CNT_W'(NWORDS))
          cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid)
      shreg <= full[SH_W-1:0];
    if (complete) begin
      req_wr   <= typ == WORD_W'(TYPE_WR);
      req_addr <= full[DATA_W +: ADDR_W];
      req_data <= full[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/rah_addr_decode.sv
module rah_addr_decode
  import rah_pkg::*;
(
  input  logic [7:0]       sel,
  output logic             hit,
  output logic [TGT_W-1:0] tgt
);
  logic [3:0] dom;
  logic [3:0] sub;

  assign dom = sel[7:4];
  assign sub = sel[3:0];

  always_comb begin
    hit = 1'b0;
    tgt = '0;
    unique case (dom)
      4'h0, 4'h1: begin
        hit = 1'b1;
        tgt = '0;
      end
      4'h2: begin
        if (sub <= 4'h2) begin
          hit = 1'b1;
          tgt = TGT_W'(sub + 4'd1);
        end else if (sub >= 4'h4 && sub <= 4'hD) begin
          hit = 1'b1;
          tgt = TGT_W'(sub);
        end
      end
      default: begin
        hit = 1'b0;
        tgt = '0;
      end
    endcase
  end
endmodule

// File: rtl/rah_stub_regs.sv
module rah_stub_regs #(
  parameter int DATA_W  = 32,
  parameter int NUM_TGT = 14,
  parameter int TGT_W   = 4,
  parameter int IDX_W   = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [TGT_W-1:0]  tgt,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int NREG  = 1 << IDX_W;
  localparam int DEPTH = NUM_TGT * NREG;
  localparam int MA_W  = TGT_W + IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [MA_W-1:0]   ma;

  assign ma = {tgt, idx};

  always_ff @(posedge clk) begin
    if (we)
      mem[ma] <= wdata;
    rdata <= mem[ma];
  end
endmodule

// File: rtl/rah_udp_reg_handler.sv
module rah_udp_reg_handler
  import rah_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [15:0]       in_dport,
  input  logic [WORD_W-1:0] in_data,
  output logic              rsp_valid,
  output logic [15:0]       rsp_type,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data
);
  logic              req_v;
  logic              req_wr;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_data;
  logic              hit;
  logic [TGT_W-1:0]  tgt;
  logic [DATA_W-1:0] rd_data;

  logic              s1_v;
  logic              s1_wr;
  logic              s1_hit;
  logic [ADDR_W-1:0] s1_addr;
  logic [DATA_W-1:0] s1_data;

  rah_req_parser #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) parser_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
    .in_dport(in_dport), .in_data(in_data),
    .req_v(req_v), .req_wr(req_wr), .req_addr(req_addr), .req_data(req_data)
  );

  rah_addr_decode decode_i (
    .sel(req_addr[ADDR_W-1 -: 8]),
    .hit(hit),
    .tgt(tgt)
  );

  rah_stub_regs #(
    .DATA_W(DATA_W), .NUM_TGT(NUM_TGT), .TGT_W(TGT_W), .IDX_W(IDX_W)
  ) regs_i (
    .clk(clk),
    .we(req_v && req_wr && hit),
    .tgt(tgt),
    .idx(req_addr[IDX_W-1:0]),
    .wdata(req_data),
    .rdata(rd_data)
  );

  // access stage: register bank is read in the same edge
  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else     s1_v <= req_v;
  end

  always_ff @(posedge clk) begin
    s1_wr   <= req_wr;
    s1_hit  <= hit;
    s1_addr <= req_addr;
    s1_data <= req_data;
  end

  // response stage
  always_ff @(posedge clk) begin
    if (rst) rsp_valid <= 1'b0;
    else     rsp_valid <= s1_v;
  end

  always_ff @(posedge clk) begin
    rsp_type <= s1_wr ? TYPE_WR : TYPE_RD;
    rsp_addr <= s1_addr;
    if (!s1_hit)    rsp_data <= '0;
    else if (s1_wr) rsp_data <= s1_data;
    else            rsp_data <= rd_data;
  end
endmodule

// File: rtl/rah_chk.sv
module rah_chk
  import rah_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              rsp_valid,
  input logic [15:0]       rsp_type,
  input logic [7:0]        rsp_sel,
  input logic [DATA_W-1:0] rsp_data
);
  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R9
  rsp_origin_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(in_valid, 3));

  // R6
  rsp_type_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_type == TYPE_RD || rsp_type == TYPE_WR));

  // R5
  unused_dom_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_sel[7:4] > 4'h2) |-> rsp_data == '0);

  // R5
  unused_sub_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_sel[7:4] == 4'h2 &&
     (rsp_sel[3:0] == 4'h3 || rsp_sel[3:0] >= 4'hE)) |-> rsp_data == '0);

  // R10
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rsp_valid);
endmodule

bind rah_udp_reg_handler rah_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .rsp_valid(rsp_valid),
  .rsp_type(rsp_type), .rsp_sel(rsp_addr[ADDR_W-1 -: 8]), .rsp_data(rsp_data)
);

// File: tb/rah_udp_reg_handler_tb_top.sv
module rah_udp_reg_handler_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_last = 1'b0;
  logic [15:0] in_dport = 16'd0;
  logic [15:0] in_data = 16'd0;
  logic        rsp_valid;
  logic [15:0] rsp_type;
  logic [31:0] rsp_addr;
  logic [31:0] rsp_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rsp_cnt = 0;
  int t5 = 0;
  int cap_cyc = 0;
  logic [15:0] cap_type;
  logic [31:0] cap_addr;
  logic [31:0] cap_data;
  logic [31:0] model [14][4];

  always #10 clk = ~clk;

  rah_udp_reg_handler dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
    .in_dport(in_dport), .in_data(in_data),
    .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_addr(rsp_addr), .rsp_data(rsp_data)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      rsp_cnt  = rsp_cnt + 1;
      cap_cyc  = cyc;
      cap_type = rsp_type;
      cap_addr = rsp_addr;
      cap_data = rsp_data;
    end
  end

  function automatic logic [31:0] tgt_addr(int t, int idx);
    int dom = (t == 0) ? 0 : 2;
    int sub = (t == 0) ? 0 : (t <= 3 ? t - 1 : t);
    return {4'(dom), 4'(sub), 22'h0, 2'(idx)};
  endfunction

  function automatic logic [31:0] pattern(int t, int idx, int salt);
    return 32'h5A00_0000 ^ (32'(t) << 16) ^ (32'(idx) << 8) ^ 32'(salt);
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send(logic [15:0] port, logic [15:0] typ, logic [31:0] addr,
                      logic [31:0] data, int nw);
    for (int i = 0; i < nw; i++) begin
      logic [15:0] w;
      @(negedge clk);
      case (i)
        0: w = typ;
        1: w = addr[31:16];
        2: w = addr[15:0];
        3: w = data[31:16];
        4: w = data[15:0];
        default: w = 16'hBEEF;
      endcase
      in_valid = 1'b1;
      in_data  = w;
      in_dport = port;
      in_last  = (i == nw - 1);
      if (i == 4) t5 = cyc;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic xact(string req, logic [15:0] port, logic [15:0] typ, logic [31:0] addr,
                      logic [31:0] data, int nw, bit exp_rsp, logic [31:0] exp_data);
    int n0 = rsp_cnt;
    send(port, typ, addr, data, nw);
    repeat (5) @(negedge clk);
    if (exp_rsp) begin
      check(rsp_cnt == n0 + 1, req, "response count", 32'(rsp_cnt), 32'(n0 + 1));
      if (rsp_cnt == n0 + 1) begin
        check(cap_type == typ, req, "type", {16'h0, cap_type}, {16'h0, typ});
        check(cap_addr == addr, req, "address", cap_addr, addr);
        check(cap_data == exp_data, req, "data", cap_data, exp_data);
        // R9 latency from the edge taking the fifth word
        check(cap_cyc - t5 == 3, "R9", "latency", 32'(cap_cyc - t5), 32'd3);
      end
    end else begin
      check(rsp_cnt == n0, req, "no response", 32'(rsp_cnt), 32'(n0));
    end
  endtask

  task automatic reread_all(string req);
    for (int t = 0; t < 14; t++)
      for (int k = 0; k < 4; k++)
        xact(req, 16'd1001, 16'h2000, tgt_addr(t, k), 32'h0, 5, 1'b1, model[t][k]);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10
    check(rsp_valid == 1'b0, "R10", "valid after reset", {31'h0, rsp_valid}, 32'h0);

    // R2 / R4: write every register of every group
    for (int t = 0; t < 14; t++)
      for (int k = 0; k < 4; k++) begin
        model[t][k] = pattern(t, k, 0);
        xact("R2", 16'd1001, 16'h2001, tgt_addr(t, k), model[t][k], 5, 1'b1, model[t][k]);
      end
    // R1 / R4: read them all back, groups distinct
    reread_all("R1");

    // R3: domain 0x1 aliases domain 0x0
    for (int k = 0; k < 4; k++)
      xact("R3", 16'd1001, 16'h2000, {4'h1, 4'h7, 22'h0, 2'(k)}, 32'h0, 5, 1'b1, model[0][k]);
    model[0][1] = pattern(0, 1, 77);
    xact("R3", 16'd1001, 16'h2001, 32'h1000_0001, model[0][1], 5, 1'b1, model[0][1]);
    xact("R3", 16'd1001, 16'h2000, 32'h0000_0001, 32'h0, 5, 1'b1, model[0][1]);

    // R4: bits 23:2 ignored
    xact("R4", 16'd1001, 16'h2000, tgt_addr(5, 2) | 32'h00FF_FFFC, 32'h0, 5, 1'b1, model[5][2]);
    xact("R4", 16'd1001, 16'h2000, tgt_addr(13, 3) | 32'h0055_AA00, 32'h0, 5, 1'b1, model[13][3]);

    // R5: unused domains and subsystems
    for (int d = 3; d < 16; d++) begin
      xact("R5", 16'd1001, 16'h2001, {4'(d), 4'h0, 24'h1}, 32'hDEAD_0000 | 32'(d), 5, 1'b1, 32'h0);
      xact("R5", 16'd1001, 16'h2000, {4'(d), 4'h0, 24'h1}, 32'h0, 5, 1'b1, 32'h0);
    end
    for (int s = 0; s < 3; s++) begin
      logic [3:0] sub = (s == 0) ? 4'h3 : (s == 1 ? 4'hE : 4'hF);
      xact("R5", 16'd1001, 16'h2001, {4'h2, sub, 24'h2}, 32'hBAD0_0000 | 32'(s), 5, 1'b1, 32'h0);
      xact("R5", 16'd1001, 16'h2000, {4'h2, sub, 24'h2}, 32'h0, 5, 1'b1, 32'h0);
    end

    // R6: illegal type codes
    xact("R6", 16'd1001, 16'h2002, tgt_addr(0, 0), 32'h6666_0001, 5, 1'b0, 32'h0);
    xact("R6", 16'd1001, 16'h0000, tgt_addr(3, 1), 32'h6666_0002, 5, 1'b0, 32'h0);
    xact("R6", 16'd1001, 16'h1FFF, tgt_addr(7, 2), 32'h6666_0003, 5, 1'b0, 32'h0);
    xact("R6", 16'd1001, 16'hA001, tgt_addr(12, 3), 32'h6666_0004, 5, 1'b0, 32'h0);

    // R7: wrong destination port
    xact("R7", 16'd1000, 16'h2001, tgt_addr(1, 0), 32'h7777_0001, 5, 1'b0, 32'h0);
    xact("R7", 16'd1002, 16'h2001, tgt_addr(2, 1), 32'h7777_0002, 5, 1'b0, 32'h0);
    xact("R7", 16'd0, 16'h2000, tgt_addr(2, 1), 32'h0, 5, 1'b0, 32'h0);

    // R8: short frames dropped, long frames served once
    xact("R8", 16'd1001, 16'h2001, tgt_addr(4, 0), 32'h8888_0001, 3, 1'b0, 32'h0);
    xact("R8", 16'd1001, 16'h2001, tgt_addr(4, 1), 32'h8888_0002, 4, 1'b0, 32'h0);
    xact("R8", 16'd1001, 16'h2000, tgt_addr(4, 0), 32'h0, 5, 1'b1, model[4][0]);
    model[6][2] = pattern(6, 2, 99);
    xact("R8", 16'd1001, 16'h2001, tgt_addr(6, 2), model[6][2], 8, 1'b1, model[6][2]);
    xact("R8", 16'd1001, 16'h2000, tgt_addr(6, 2), 32'h0, 7, 1'b1, model[6][2]);

    // R5 R6 R7 R8: no stray writes anywhere
    reread_all("R5");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule